// File: doc/BRIEF.md
# Serial-Flash Write-Enable Gate

This block is the command front end of a serial-flash slave. While chip select is low it shifts in command bits on the serial data input, most significant bit first, on rising serial clock edges (SPI mode 0). It keeps one write-enable flag. Commands that change the memory (program, erase, sector lock and unlock, status write) are passed to the downstream engines only when that flag is already set. The flag changes only when chip select rises cleanly. "Cleanly" means a full opcode byte was received and the total clock count is a whole number of bytes.

The serial pins are asynchronous to the system clock. They are synchronised into a system clock that runs at least four times faster than the serial clock, and their edges are detected in that domain. Guarded opcodes leave the block on a valid/ready stream towards the engines. A stream beat is offered when the eighth opcode bit arrives. It is held, unchanged, until the engine accepts it. Only one beat can be pending: a guarded opcode that arrives while a beat is still pending is dropped, so back-pressure never stalls the serial side. When an engine finishes its work, it pulses a done input, and that clears the flag.

Top module: `wel_gate_top`

## Requirements
- R1: The opcode is the first eight bits sampled on `spi_mosi` at rising `spi_sck` edges while `spi_cs_n` is low, with the most significant bit first. The system clock runs at least four times faster than `spi_sck`.
- R2: Opcode 0x06 sets the write-enable flag when `spi_cs_n` rises, and not before. The rise must come after a full opcode and at a bit count that is a multiple of 8.
- R3: If `spi_cs_n` rises before eight bits have been received, the frame is aborted and the flag keeps its value.
- R4: If `spi_cs_n` rises after a bit count that is not a multiple of 8, the frame is aborted and the flag keeps its value.
- R5: Bytes that follow the opcode within the same frame have no effect on the result.
- R6: Opcode 0x04 clears the flag when its frame ends cleanly. An aborted 0x04 frame leaves the flag unchanged.
- R7: The guarded opcodes are 0x02, 0x20, 0x52, 0xD8, 0x60, 0xC7, 0x36, 0x39 and 0x01. Each is offered on the stream only if the flag is 1 when its eighth bit arrives. Otherwise it is dropped.
- R8: `cmd_valid` stays high with `cmd_op` stable until a cycle in which `cmd_ready` is high. Guarded opcodes that arrive while a beat is pending are dropped.
- R9: A `cmd_done` pulse clears the flag. It takes priority over a set in the same cycle.
- R10: `status` bit 1 equals the flag and all other status bits are 0. `so_oe` stays 0, so the serial output is never driven.
- R11: After reset the flag is 0 and `cmd_valid` is 0.
- R12: A falling `spi_cs_n` clears the bit count and the shift register, so bits from an aborted frame never combine with the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | Serial clock (asynchronous) |
| spi_cs_n | input | 1 | Chip select, active low (asynchronous) |
| spi_mosi | input | 1 | Serial data in |
| so_oe | output | 1 | Serial output enable, always 0 here |
| cmd_valid | output | 1 | Guarded command offered to engines |
| cmd_ready | input | 1 | Engine accepts the offered command |
| cmd_op | output | 8 | Opcode of the offered command |
| cmd_done | input | 1 | Engine finished a guarded command |
| status | output | 8 | Status byte, bit 1 = write-enable flag |

## Verification
Assertions check on every cycle that the flag moves only in the cycle after a chip-select rise or a done pulse. They also check that a beat is launched only when the flag is set, that a stalled beat holds its opcode, and that a chip-select fall empties the bit counter. Only the bench's frames can show the abort rules: short frames, ragged bit counts, ignored trailing bytes and leakage across frames. The bench also shows the timing of the set at chip-select rise, the priority of done over set, and the drop of a guarded opcode while a beat is pending.

// File: rtl/wel_gate_pkg.sv
package wel_gate_pkg;
  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] OP_FLAG_SET = 8'h06;
  localparam logic [OP_W-1:0] OP_FLAG_CLR = 8'h04;

  function automatic logic op_is_guarded(input logic [OP_W-1:0] op);
    case (op)
      8'h02, 8'h20, 8'h52, 8'hD8, 8'h60,
      8'hC7, 8'h36, 8'h39, 8'h01: op_is_guarded = 1'b1;
      default:                    op_is_guarded = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] pin_rst_val,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain <= {STAGES{pin_rst_val[b]}};
        last  <= pin_rst_val[b];
      end else begin
        chain <= {chain[STAGES-2:0], pin_in[b]};
        last  <= chain[STAGES-1];
      end
    end
    assign level[b] = chain[STAGES-1];
    assign rise[b]  = chain[STAGES-1] & ~last;
    assign fall[b]  = ~chain[STAGES-1] & last;
  end
endmodule

// File: rtl/op_shifter.sv
module op_shifter
  import wel_gate_pkg::*;
#(
  parameter int BITS = OP_W,
  localparam int CW  = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            sel_fall,
  input  logic            sck_rise,
  input  logic            mosi,
  output logic [BITS-1:0] op,
  output logic            op_done,
  output logic            have_op,
  output logic            aligned
);
  logic [BITS-1:0] shreg;
  logic [CW-1:0]   cnt;
  logic [BITS-1:0] shnext;

  assign shnext  = {shreg[BITS-2:0], mosi};
  assign aligned = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      cnt     <= '0;
      op      <= '0;
      have_op <= 1'b0;
      op_done <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (sel_fall) begin
        shreg   <= '0;
        cnt     <= '0;
        have_op <= 1'b0;
      end else if (sck_rise && sel) begin
        shreg <= shnext;
        cnt   <= (cnt == CW'(BITS - 1)) ? '0 : cnt + 1'b1;
        if (cnt == CW'(BITS - 1) && !have_op) begin
          op      <= shnext;
          have_op <= 1'b1;
          op_done <= 1'b1;
        end
      end
    end
  end

  // R12: a falling select always leaves an empty frame behind
  a_r12_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fall |=> (aligned && !have_op));
  // R1: opcode capture only on an active serial clock edge
  a_r1_capture_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(have_op) |-> $past(sck_rise && sel));
endmodule

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import wel_gate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_rise,
  input  logic            have_op,
  input  logic            aligned,
  input  logic [OP_W-1:0] op,
  input  logic            op_done,
  input  logic            cmd_done,
  input  logic            cmd_ready,
  output logic            wel,
  output logic            cmd_valid,
  output logic [OP_W-1:0] cmd_op
);
  logic clean_end;
  logic launch;

  assign clean_end = sel_rise && have_op && aligned;
  assign launch    = op_done && op_is_guarded(op) && wel && !cmd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (cmd_done) begin
      wel <= 1'b0;
    end else if (clean_end && op == OP_FLAG_SET) begin
      wel <= 1'b1;
    end else if (clean_end && op == OP_FLAG_CLR) begin
      wel <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
    end else if (launch) begin
      cmd_valid <= 1'b1;
      cmd_op    <= op;
    end else if (cmd_valid && cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  // R2, R9: the flag only moves after a select rise or a done pulse
  a_r2_flag_moves_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (wel != $past(wel)) |-> ($past(sel_rise) || $past(cmd_done)));
  // R7: a beat starts only while the flag is set
  a_r7_launch_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(wel));
  // R8: a stalled beat holds its opcode
  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op)));
  // R9: done clears the flag
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !wel);
endmodule

// File: rtl/wel_gate_top.sv
module wel_gate_top
  import wel_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spi_sck,
  input  logic            spi_cs_n,
  input  logic            spi_mosi,
  output logic            so_oe,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic [OP_W-1:0] cmd_op,
  input  logic            cmd_done,
  output logic [7:0]      status
);
  localparam int NPIN = 3;
  localparam int P_SCK = 0;
  localparam int P_CS = 1;
  localparam int P_DI = 2;

  logic [NPIN-1:0] pins, lvl, rs, fl;
  logic [OP_W-1:0] op;
  logic op_done, have_op, aligned, wel;

  assign pins = {spi_mosi, spi_cs_n, spi_sck};

  pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .pin_rst_val(3'b010),
    .level(lvl), .rise(rs), .fall(fl)
  );

  op_shifter #(.BITS(OP_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel(~lvl[P_CS]), .sel_fall(fl[P_CS]),
    .sck_rise(rs[P_SCK]), .mosi(lvl[P_DI]), .op(op), .op_done(op_done),
    .have_op(have_op), .aligned(aligned)
  );

  flag_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_rise(rs[P_CS]), .have_op(have_op),
    .aligned(aligned), .op(op), .op_done(op_done), .cmd_done(cmd_done),
    .cmd_ready(cmd_ready), .wel(wel), .cmd_valid(cmd_valid), .cmd_op(cmd_op)
  );

  assign so_oe  = 1'b0;
  assign status = {6'b0, wel, 1'b0};
endmodule

// File: tb/tb_wel_gate_top.sv
`timescale 1ns/1ps
module tb_wel_gate_top;
  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic cmd_ready = 0, cmd_done = 0;
  logic so_oe, cmd_valid;
  logic [7:0] cmd_op, status;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wel_gate_top dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .so_oe(so_oe), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_done(cmd_done), .status(status)
  );

  // {opcode, bit count, expected flag after frame}; walked in order
  localparam logic [14:0] VEC [0:8] = '{
    {8'h06, 6'd8,  1'b1},  // R2 clean set
    {8'h04, 6'd8,  1'b0},  // R6 clean clear
    {8'h06, 6'd5,  1'b0},  // R3 short frame
    {8'h06, 6'd12, 1'b0},  // R4 ragged count
    {8'h06, 6'd24, 1'b1},  // R5 trailing bytes
    {8'h04, 6'd7,  1'b1},  // R3 short clear aborted
    {8'h04, 6'd16, 1'b0},  // R6 clear with extra byte
    {8'h06, 6'd16, 1'b1},  // R5
    {8'h04, 6'd9,  1'b1}   // R4 ragged clear aborted
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_begin();
    @(negedge clk); cs_n = 0; clks(4);
  endtask

  task automatic frame_bits(input logic [7:0] op, input int n);
    for (int i = 0; i < n; i++) begin
      mosi = (i < 8) ? op[7-i] : 1'b0;
      sck = 0; clks(4);
      sck = 1; clks(4);
    end
    sck = 0; clks(4);
  endtask

  task automatic frame_end();
    cs_n = 1; clks(8);
  endtask

  task automatic frame(input logic [7:0] op, input int n);
    frame_begin(); frame_bits(op, n); frame_end();
  endtask

  initial begin
    #1200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clks(4); rst_n = 1; clks(2);
    chk("R11 flag after reset", status, 8'h00);
    chk("R11 valid after reset", {7'b0, cmd_valid}, 8'h00);

    for (int v = 0; v < 9; v++) begin
      frame(VEC[v][14:7], int'(VEC[v][6:1]));
      chk($sformatf("R2-vector %0d flag", v), {7'b0, status[1]}, {7'b0, VEC[v][0]});
      chk("R10 status other bits", status & 8'hFD, 8'h00);
      chk("R10 so_oe", {7'b0, so_oe}, 8'h00);
    end

    // R8: flag is 1; guarded beat stalls, later guarded opcode dropped
    frame(8'h02, 8);
    chk("R7 beat offered", {7'b0, cmd_valid}, 8'h01);
    chk("R1 opcode msb first", cmd_op, 8'h02);
    frame(8'h20, 16);
    chk("R8 beat held", {7'b0, cmd_valid}, 8'h01);
    chk("R8 opcode stable", cmd_op, 8'h02);
    cmd_ready = 1; clks(1); cmd_ready = 0; clks(1);
    chk("R8 beat accepted", {7'b0, cmd_valid}, 8'h00);
    cmd_done = 1; clks(1); cmd_done = 0; clks(1);
    chk("R9 done clears flag", {7'b0, status[1]}, 8'h00);

    // R7: flag 0, guarded opcode dropped
    frame(8'hD8, 8);
    chk("R7 dropped without flag", {7'b0, cmd_valid}, 8'h00);

    // R2: not set before select rises
    frame_begin(); frame_bits(8'h06, 8); clks(8);
    chk("R2 flag not set while selected", {7'b0, status[1]}, 8'h00);
    frame_end();
    chk("R2 flag set at select rise", {7'b0, status[1]}, 8'h01);

    // R1: guarded opcode with nonzero low bits
    frame(8'hC7, 8);
    chk("R1 opcode C7", cmd_op, 8'hC7);
    cmd_ready = 1; clks(2); cmd_ready = 0;
    cmd_done = 1; clks(1); cmd_done = 0; clks(1);

    // R9: done held across a clean set frame wins
    frame_begin(); frame_bits(8'h06, 8); cmd_done = 1; frame_end(); cmd_done = 0; clks(2);
    chk("R9 done beats set", {7'b0, status[1]}, 8'h00);

    // R12: aborted prefix must not combine with next frame
    frame(8'h00, 4);
    frame(8'h60, 4);   // bits 0110
    chk("R12 no leakage", {7'b0, status[1]}, 8'h00);

    // R11: reset mid-run clears flag
    frame(8'h06, 8);
    chk("R2 set before reset", {7'b0, status[1]}, 8'h01);
    rst_n = 0; clks(3); rst_n = 1; clks(2);
    chk("R11 reset clears flag", status, 8'h00);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule